// File: doc/BRIEF.md
# Serial Character Receiver with Flagged Two-Entry Queue

This block recovers asynchronous serial characters from a single input line. It waits for the idle-high line to fall, checks that the low level is still there at the middle of the start bit, and then takes one sample per bit at the bit centre. It uses a tick that runs at sixteen times the bit rate, and it shifts the data bits in least significant bit first. The character length runs from five to nine bits, and a parity bit can follow the data. The block examines only the first stop bit and treats the character as complete as soon as it has sampled that bit.

Each completed character goes into a queue with two slots. A slot holds the data, the ninth bit and three status flags that belong to that character alone: frame, overrun and parity. The host always sees the oldest slot and removes it with a one-cycle read strobe. A ready flag shows that the queue is not empty. An interrupt line follows that flag while its enable is set. Lowering the receive enable empties the queue and parks the line monitor.

Top module: `serial_rx_fifo`

## Requirements
- R1: When the receive enable is 1, a falling edge on the line starts a character only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit time produces no character.
- R2: The data bits are taken least significant bit first. The size code selects 5, 6, 7 or 8 bits for values 0 to 3, 9 bits for value 7, and 8 bits for values 4 to 6. The unused upper bits of `rx_data` read 0.
- R3: With size code 7, the ninth received bit appears on `rx_bit8`. For every other size, `rx_bit8` reads 0.
- R4: With `par_en` set, one parity bit follows the data. It is even when `par_odd` is 0 and odd when it is 1. `err_par` is 1 exactly when the received parity bit is wrong. With `par_en` clear, `err_par` is 0.
- R5: `err_frame` is 1 when the first stop bit is sampled as 0, and 0 when it is sampled as 1.
- R6: A character becomes available after its first stop bit alone. A new start bit may follow that stop bit at once, and both characters are received.
- R7: The queue holds two characters in order. `rx_ready` is 1 while at least one character is unread. A `rd_pop` pulse removes the oldest character and shows the next one.
- R8: A character that completes while both slots are full is discarded. The overrun flag of the most recently written slot is set, and the older slot's flag stays 0.
- R9: `err_frame`, `err_over` and `err_par` always belong to the character presented on `rx_data`.
- R10: Setting `rx_en` to 0 empties both slots, so that `rx_ready` reads 0 on the next cycle and stays 0.
- R11: `rx_irq` equals `rx_ready` AND `irq_en` at every cycle.
- R12: After reset, `rx_ready`, `rx_irq`, `rx_data`, `rx_bit8` and all three flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; 0 flushes the queue |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| size_code | input | 3 | Character length select |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| irq_en | input | 1 | Interrupt enable |
| rd_pop | input | 1 | Removes the oldest character |
| rx_ready | output | 1 | Queue not empty |
| rx_irq | output | 1 | Receive interrupt |
| rx_data | output | 8 | Low eight bits of the oldest character |
| rx_bit8 | output | 1 | Ninth bit of the oldest character |
| err_frame | output | 1 | Frame error of the oldest character |
| err_over | output | 1 | Overrun flag of the oldest character |
| err_par | output | 1 | Parity error of the oldest character |

## Verification
A bit counter or oversample phase that slips shows up as data shifted by one position or as false frame errors on the very next character. A queue pointer that slips shows up after the next pop as a character out of order, or with another character's flags. An overrun flag written into the wrong slot is visible only after one pop, so the bench fills the queue, overflows it and then drains it while checking the flags of each slot. Any of these faults reaches the ports within one character time plus one pop.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int MAX_BITS = 9;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                fe;
    logic                pe;
  } srx_frame_t;

  function automatic logic [3:0] size_to_bits(input logic [2:0] code);
    case (code)
      3'd0:    size_to_bits = 4'd5;
      3'd1:    size_to_bits = 4'd6;
      3'd2:    size_to_bits = 4'd7;
      3'd7:    size_to_bits = 4'd9;
      default: size_to_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output srx_frame_t frame
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                 st;
  logic [CW-1:0]       cnt;
  logic [3:0]          bitn;
  logic [MAX_BITS-1:0] sh;
  logic                pbit;
  logic [MAX_BITS-1:0] aligned;

  assign aligned = sh >> (4'(MAX_BITS) - nbits);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      if (rst) frame <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (!rxd) st <= S_START;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rxd ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              sh   <= {rxd, sh[MAX_BITS-1:1]};
              bitn <= bitn + 1'b1;
              if (bitn == nbits - 4'd1) st <= par_en ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              pbit <= rxd;
              st   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              frame.data <= aligned;
              frame.fe   <= ~rxd;
              frame.pe   <= par_en & (^aligned ^ pbit ^ par_odd);
              done       <= 1'b1;
              st         <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       push,
  input  srx_frame_t wdata,
  input  logic       pop,
  output srx_frame_t head,
  output logic       head_ovr,
  output logic       nonempty
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CTW = $clog2(DEPTH + 1);
  localparam logic [CTW-1:0] FULL = CTW'(DEPTH);

  srx_frame_t     mem [DEPTH];
  logic [DEPTH-1:0] ovr_q;
  logic [AW-1:0]  wr_ptr, rd_ptr, last_ptr;
  logic [CTW-1:0] cnt;
  logic           do_push, do_pop, lost;

  assign do_pop   = pop && (cnt != '0) && !flush;
  assign do_push  = push && !flush && ((cnt != FULL) || do_pop);
  assign lost     = push && !flush && !do_push;
  assign last_ptr = wr_ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovr_q  <= '0;
    end else begin
      if (do_push) begin
        wr_ptr         <= wr_ptr + 1'b1;
        ovr_q[wr_ptr]  <= 1'b0;
      end
      if (lost) ovr_q[last_ptr] <= 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign nonempty = (cnt != '0);
  assign head     = nonempty ? mem[rd_ptr] : '0;
  assign head_ovr = nonempty & ovr_q[rd_ptr];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  p_pop_dec_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !flush && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && cnt == FULL) |=> (cnt == FULL));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [2:0] size_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       irq_en,
  input  logic       rd_pop,
  output logic       rx_ready,
  output logic       rx_irq,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       err_frame,
  output logic       err_over,
  output logic       err_par
);
  logic [1:0] sync_q;
  logic       done;
  srx_frame_t frame, head;
  logic       head_ovr;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  srx_sampler #(.OVS(OVS)) u_samp (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick16), .rxd(sync_q[1]),
    .nbits(size_to_bits(size_code)), .par_en(par_en), .par_odd(par_odd),
    .done(done), .frame(frame)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(!rx_en), .push(done), .wdata(frame),
    .pop(rd_pop), .head(head), .head_ovr(head_ovr), .nonempty(rx_ready)
  );

  assign rx_irq    = rx_ready & irq_en;
  assign rx_data   = head.data[7:0];
  assign rx_bit8   = head.data[8];
  assign err_frame = head.fe;
  assign err_par   = head.pe;
  assign err_over  = head_ovr;

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_ready);
endmodule

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
  localparam int CLK_NS  = 10;
  localparam int TDIV    = 4;
  localparam int BIT_CLK = 16 * TDIV;
  localparam int WD_MAX  = 150000;

  // vector: [15:13] size, [12] par_en, [11] par_odd, [10] bad parity, [9] stop value, [8:0] data
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1F3},
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h02D},
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 9'h055},
    {3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 9'h13C},
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0C3},
    {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 9'h081},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'h07E},
    {3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1FF},
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h011}
  };

  logic clk = 0, rst = 1, rx_en = 0, tick16 = 0, rxd = 1;
  logic [2:0] size_code = 3'd3;
  logic par_en = 0, par_odd = 0, irq_en = 0, rd_pop = 0;
  logic rx_ready, rx_irq, rx_bit8, err_frame, err_over, err_par;
  logic [7:0] rx_data;
  int errors = 0, checks = 0, cyc = 0, tdiv = 0;

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= (tdiv == TDIV-1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == TDIV-1);
    cyc    <= cyc + 1;
    if (cyc == WD_MAX) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tick16(tick16), .rxd(rxd),
    .size_code(size_code), .par_en(par_en), .par_odd(par_odd),
    .irq_en(irq_en), .rd_pop(rd_pop), .rx_ready(rx_ready), .rx_irq(rx_irq),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .err_frame(err_frame),
    .err_over(err_over), .err_par(err_par)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [2:0] c);
    if (c == 3'd7) return 9;
    if (c <= 3'd3) return 5 + int'(c);
    return 8;
  endfunction

  function automatic logic [8:0] mask_of(input logic [2:0] c, input logic [8:0] d);
    return d & 9'((1 << nbits_of(c)) - 1);
  endfunction

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] sz, input logic pen, input logic podd,
                      input logic bad, input logic stopv, input logic [8:0] d, input int gap);
    logic [8:0] m;
    m = mask_of(sz, d);
    size_code = sz; par_en = pen; par_odd = podd;
    hold_bit(1'b0);
    for (int i = 0; i < nbits_of(sz); i++) hold_bit(m[i]);
    if (pen) hold_bit(^m ^ podd ^ bad);
    hold_bit(stopv);
    for (int i = 0; i < gap; i++) hold_bit(1'b1);
  endtask

  task automatic pop1();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 ready", rx_ready, 0);
    chk("R12 irq", rx_irq, 0);
    chk("R12 data", {rx_bit8, rx_data}, 0);
    chk("R12 flags", {err_frame, err_over, err_par}, 0);
    rst = 0;
    rx_en = 1;
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      logic [8:0] m;
      send(VEC[v][15:13], VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8:0], 1);
      m = mask_of(VEC[v][15:13], VEC[v][8:0]);
      chk("R7 ready after char", rx_ready, 1);
      chk("R2 data", rx_data, m[7:0]);
      chk("R3 bit8", rx_bit8, m[8]);
      chk("R4 parity flag", err_par, VEC[v][12] & VEC[v][10]);
      chk("R5 frame flag", err_frame, !VEC[v][9]);
      chk("R9 over flag", err_over, 0);
      pop1();
      chk("R7 empty after pop", rx_ready, 0);
    end

    // R1 false start: short low glitch
    rxd = 0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk("R1 glitch ignored", rx_ready, 0);

    // R6 back to back, one stop bit each; R11 interrupt gating
    send(3'd3, 0, 0, 0, 1, 9'h3C, 0);
    send(3'd3, 0, 0, 0, 1, 9'hC3, 1);
    chk("R6 first char", rx_data, 8'h3C);
    chk("R11 irq masked", rx_irq, 0);
    irq_en = 1;
    @(negedge clk);
    chk("R11 irq on", rx_irq, 1);
    pop1();
    chk("R6 second char", rx_data, 8'hC3);
    pop1();
    chk("R11 irq off when empty", rx_irq, 0);

    // R8 overrun: three chars, queue of two; R9 per-slot flags
    send(3'd3, 0, 0, 0, 0, 9'h11, 1);
    send(3'd3, 0, 0, 0, 1, 9'h22, 1);
    send(3'd3, 0, 0, 0, 1, 9'h33, 1);
    chk("R8 head kept", rx_data, 8'h11);
    chk("R8 older slot flag", err_over, 0);
    chk("R9 head frame flag", err_frame, 1);
    pop1();
    chk("R8 second kept", rx_data, 8'h22);
    chk("R8 newest slot flag", err_over, 1);
    chk("R9 second frame flag", err_frame, 0);
    pop1();
    chk("R8 third discarded", rx_ready, 0);

    // R10 flush on disable
    send(3'd3, 0, 0, 0, 1, 9'h5A, 1);
    send(3'd3, 0, 0, 0, 1, 9'hA5, 1);
    chk("R10 full before flush", rx_ready, 1);
    rx_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 flushed", rx_ready, 0);
    chk("R10 irq low", rx_irq, 0);
    rx_en = 1;
    repeat (4) @(negedge clk);
    chk("R10 stays empty", rx_ready, 0);
    send(3'd3, 0, 0, 0, 1, 9'h96, 1);
    chk("R10 receives after enable", rx_data, 8'h96);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule